// File: doc/BRIEF.md
# Bit-Striped Parity Lane Engine

This block spreads each byte written to it across a row of single-bit storage lanes. Data bit i goes to data lane i. One extra lane stores the even parity of the byte. Every write drives all lanes in the same cycle with the same address, because each write recomputes the parity. The block therefore models a bit-interleaved redundant disk array at the bus level. The redundancy costs one lane for every eight data lanes, or 12.5 percent.

A read first asks only the data lanes for their bits at the read address. Lanes may answer in any cycle and in any order. When every data lane has answered cleanly, the byte is reassembled from the lanes. If exactly one data lane reports an error, the engine then asks the parity lane. It rebuilds the bad bit from the seven good bits and the parity bit, and marks the result as recovered. Two or more data-lane errors, or a data-lane error together with a parity-lane error, make the result uncorrectable.

Top module: `bitstripe_engine`

## Requirements
- R1: One cycle after `wr_valid_i` is sampled high, `lane_wr_bit_o[i]` equals bit i of `wr_data_i` for every data lane i, and `lane_wr_addr_o` equals `wr_addr_i`.
- R2: On a write, the parity lane (index 8) carries the even parity of the data bits, so the XOR of all nine lane bits is 0.
- R3: A write raises all nine `lane_wr_valid_o` bits together, for exactly one cycle.
- R4: A read whose data lanes all answer without error sends no request to the parity lane (`lane_rd_req_o[8]` stays 0). The data lanes receive exactly one one-cycle request pulse, which carries the read address.
- R5: After a clean read, `rd_data_o[i]` equals the bit returned by data lane i, with `rd_fix_o` = 0 and `rd_unc_o` = 0.
- R6: If exactly one data lane flags `lane_rd_err_i`, one parity-lane request is issued after the last data lane answers. The result then carries the original byte, rebuilt as the XOR of the other data bits and the parity bit, with `rd_fix_o` = 1.
- R7: If two or more data lanes flag errors, or the parity lane flags an error during a recovery, the result has `rd_unc_o` = 1, `rd_fix_o` = 0 and `rd_data_o` = 0.
- R8: `rd_valid_o` is a single-cycle pulse. It rises in the cycle after the cycle in which the last required lane answered, and there is exactly one pulse per accepted read.
- R9: While `rst_i` is high, `lane_wr_valid_o`, `lane_rd_req_o` and `rd_valid_o` are all 0. After reset, `rd_ready_o` is 1.
- R10: A `rd_req_i` that arrives while `rd_ready_o` is 0 is ignored. It issues no data-lane request and produces no extra result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_valid_i | input | 1 | Write strobe |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | DLANES | Byte to stripe |
| rd_req_i | input | 1 | Read request, accepted when ready |
| rd_addr_i | input | AW | Read address |
| rd_ready_o | output | 1 | Engine can accept a read |
| rd_valid_o | output | 1 | Read result strobe |
| rd_data_o | output | DLANES | Reassembled byte |
| rd_fix_o | output | 1 | One lane was rebuilt from parity |
| rd_unc_o | output | 1 | Word is uncorrectable |
| lane_wr_valid_o | output | DLANES+1 | Per-lane write strobe |
| lane_wr_bit_o | output | DLANES+1 | Per-lane write bit, top bit is parity |
| lane_wr_addr_o | output | AW | Address shared by all lane writes |
| lane_rd_req_o | output | DLANES+1 | Per-lane read request pulse |
| lane_rd_addr_o | output | AW | Address shared by all lane reads |
| lane_rd_valid_i | input | DLANES+1 | Per-lane read answer strobe |
| lane_rd_bit_i | input | DLANES+1 | Per-lane read bit |
| lane_rd_err_i | input | DLANES+1 | Per-lane read error flag |

## Verification
A write and a read request can arrive in the same cycle. A new write can also arrive while a parity-based recovery is in progress. The bench issues a write to a different address in the same cycle as every read request. It then checks two things: the lane write outputs for that write, and that the read still returns the byte stored at its own address. A second read request is also raised while the engine is busy. The bench counts the lane request pulses to confirm that this request had no effect.

// File: rtl/bse_pkg.sv
package bse_pkg;
   typedef enum logic [1:0] {
      RD_IDLE = 2'd0,
      RD_DATA = 2'd1,
      RD_PAR  = 2'd2
   } rd_state_e;
endpackage

// File: rtl/bse_scatter.sv
module bse_scatter #(
   parameter int DLANES = 8,
   parameter int AW     = 4
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_valid_i,
   input  logic [AW-1:0]     wr_addr_i,
   input  logic [DLANES-1:0] wr_data_i,
   output logic [DLANES:0]   lane_wr_valid_o,
   output logic [DLANES:0]   lane_wr_bit_o,
   output logic [AW-1:0]     lane_wr_addr_o
);
   localparam int NL = DLANES + 1;

   logic [NL-1:0] bits_next;

   // one data lane per byte bit, parity lane last
   for (genvar g = 0; g < DLANES; g++) begin : g_lane
      assign bits_next[g] = wr_data_i[g];
   end
   assign bits_next[DLANES] = ^wr_data_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         lane_wr_valid_o <= '0;
         lane_wr_bit_o   <= '0;
         lane_wr_addr_o  <= '0;
      end else begin
         lane_wr_valid_o <= {NL{wr_valid_i}};
         if (wr_valid_i) begin
            lane_wr_bit_o  <= bits_next;
            lane_wr_addr_o <= wr_addr_i;
         end
      end
   end

   p_wr_follow_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      wr_valid_i |=> (lane_wr_bit_o[DLANES-1:0] == $past(wr_data_i))
                     && (lane_wr_addr_o == $past(wr_addr_i)));
   p_par_even_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      lane_wr_valid_o[DLANES] |-> (^lane_wr_bit_o) == 1'b0);
   p_all_lanes_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (|lane_wr_valid_o) |-> (&lane_wr_valid_o));
endmodule

// File: rtl/bse_rebuild.sv
module bse_rebuild #(
   parameter int DLANES = 8
) (
   input  logic [DLANES-1:0] bits_i,
   input  logic              par_i,
   input  logic [DLANES-1:0] err_i,
   output logic [DLANES-1:0] fixed_o
);
   logic [DLANES-1:0] good;
   logic              syn;

   assign good    = bits_i & ~err_i;
   // even parity: missing bit is XOR of survivors and parity
   assign syn     = (^good) ^ par_i;
   assign fixed_o = good | (err_i & {DLANES{syn}});
endmodule

// File: rtl/bse_gather.sv
module bse_gather
   import bse_pkg::*;
#(
   parameter int DLANES = 8,
   parameter int AW     = 4
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              rd_req_i,
   input  logic [AW-1:0]     rd_addr_i,
   output logic              rd_ready_o,
   output logic              rd_valid_o,
   output logic [DLANES-1:0] rd_data_o,
   output logic              rd_fix_o,
   output logic              rd_unc_o,
   output logic [DLANES:0]   lane_rd_req_o,
   output logic [AW-1:0]     lane_rd_addr_o,
   input  logic [DLANES:0]   lane_rd_valid_i,
   input  logic [DLANES:0]   lane_rd_bit_i,
   input  logic [DLANES:0]   lane_rd_err_i
);
   localparam int NL = DLANES + 1;
   localparam int CW = $clog2(DLANES + 1);
   localparam logic [NL-1:0] DATA_MASK = {1'b0, {DLANES{1'b1}}};
   localparam logic [NL-1:0] PAR_MASK  = {1'b1, {DLANES{1'b0}}};

   rd_state_e         state_q;
   logic [NL-1:0]     got_q, bit_q, err_q;
   logic [NL-1:0]     pend, take, got_n, bit_n, err_n;
   logic [CW-1:0]     derr;
   logic              data_done, par_done;
   logic [DLANES-1:0] fixed;

   always_comb begin
      case (state_q)
         RD_DATA: pend = DATA_MASK;
         RD_PAR:  pend = PAR_MASK;
         default: pend = '0;
      endcase
   end

   assign take      = lane_rd_valid_i & pend & ~got_q;
   assign got_n     = got_q | take;
   assign bit_n     = (take & lane_rd_bit_i) | (~take & bit_q);
   assign err_n     = (take & lane_rd_err_i) | (~take & err_q);
   assign derr      = CW'($countones(err_n[DLANES-1:0]));
   assign data_done = (state_q == RD_DATA) && (&got_n[DLANES-1:0]);
   assign par_done  = (state_q == RD_PAR) && got_n[DLANES];
   assign rd_ready_o = (state_q == RD_IDLE);

   bse_rebuild #(.DLANES(DLANES)) u_rebuild (
      .bits_i  (bit_n[DLANES-1:0]),
      .par_i   (bit_n[DLANES]),
      .err_i   (err_n[DLANES-1:0]),
      .fixed_o (fixed)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q        <= RD_IDLE;
         got_q          <= '0;
         bit_q          <= '0;
         err_q          <= '0;
         lane_rd_req_o  <= '0;
         lane_rd_addr_o <= '0;
         rd_valid_o     <= 1'b0;
         rd_data_o      <= '0;
         rd_fix_o       <= 1'b0;
         rd_unc_o       <= 1'b0;
      end else begin
         lane_rd_req_o <= '0;
         rd_valid_o    <= 1'b0;
         got_q         <= got_n;
         bit_q         <= bit_n;
         err_q         <= err_n;
         case (state_q)
            RD_IDLE: begin
               if (rd_req_i) begin
                  lane_rd_req_o  <= DATA_MASK;
                  lane_rd_addr_o <= rd_addr_i;
                  got_q          <= '0;
                  err_q          <= '0;
                  state_q        <= RD_DATA;
               end
            end
            RD_DATA: begin
               if (data_done) begin
                  if (derr == CW'(0)) begin
                     rd_valid_o <= 1'b1;
                     rd_data_o  <= bit_n[DLANES-1:0];
                     rd_fix_o   <= 1'b0;
                     rd_unc_o   <= 1'b0;
                     state_q    <= RD_IDLE;
                  end else if (derr == CW'(1)) begin
                     lane_rd_req_o <= PAR_MASK;
                     state_q       <= RD_PAR;
                  end else begin
                     rd_valid_o <= 1'b1;
                     rd_data_o  <= '0;
                     rd_fix_o   <= 1'b0;
                     rd_unc_o   <= 1'b1;
                     state_q    <= RD_IDLE;
                  end
               end
            end
            RD_PAR: begin
               if (par_done) begin
                  rd_valid_o <= 1'b1;
                  rd_data_o  <= err_n[DLANES] ? '0 : fixed;
                  rd_fix_o   <= ~err_n[DLANES];
                  rd_unc_o   <= err_n[DLANES];
                  state_q    <= RD_IDLE;
               end
            end
            default: state_q <= RD_IDLE;
         endcase
      end
   end

   p_par_req_on_err_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      lane_rd_req_o[DLANES] |-> (|err_q[DLANES-1:0]));
   p_fix_single_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_valid_o && rd_fix_o) |-> ($countones(err_q[DLANES-1:0]) == 1));
   p_unc_blank_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_valid_o && rd_unc_o) |-> (rd_data_o == '0) && !rd_fix_o);
   p_pulse_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      rd_valid_o |=> !rd_valid_o);
   p_busy_drop_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_req_i && !rd_ready_o) |=> (lane_rd_req_o[DLANES-1:0] == '0));
endmodule

// File: rtl/bitstripe_engine.sv
module bitstripe_engine #(
   parameter int DLANES = 8,
   parameter int AW     = 4
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_valid_i,
   input  logic [AW-1:0]     wr_addr_i,
   input  logic [DLANES-1:0] wr_data_i,
   input  logic              rd_req_i,
   input  logic [AW-1:0]     rd_addr_i,
   output logic              rd_ready_o,
   output logic              rd_valid_o,
   output logic [DLANES-1:0] rd_data_o,
   output logic              rd_fix_o,
   output logic              rd_unc_o,
   output logic [DLANES:0]   lane_wr_valid_o,
   output logic [DLANES:0]   lane_wr_bit_o,
   output logic [AW-1:0]     lane_wr_addr_o,
   output logic [DLANES:0]   lane_rd_req_o,
   output logic [AW-1:0]     lane_rd_addr_o,
   input  logic [DLANES:0]   lane_rd_valid_i,
   input  logic [DLANES:0]   lane_rd_bit_i,
   input  logic [DLANES:0]   lane_rd_err_i
);
   if (DLANES < 2) begin : g_bad_lanes
      $error("bitstripe_engine: DLANES must be at least 2");
   end
   if (AW < 1) begin : g_bad_aw
      $error("bitstripe_engine: AW must be at least 1");
   end

   bse_scatter #(.DLANES(DLANES), .AW(AW)) u_scatter (
      .clk_i           (clk_i),
      .rst_i           (rst_i),
      .wr_valid_i      (wr_valid_i),
      .wr_addr_i       (wr_addr_i),
      .wr_data_i       (wr_data_i),
      .lane_wr_valid_o (lane_wr_valid_o),
      .lane_wr_bit_o   (lane_wr_bit_o),
      .lane_wr_addr_o  (lane_wr_addr_o)
   );

   bse_gather #(.DLANES(DLANES), .AW(AW)) u_gather (
      .clk_i           (clk_i),
      .rst_i           (rst_i),
      .rd_req_i        (rd_req_i),
      .rd_addr_i       (rd_addr_i),
      .rd_ready_o      (rd_ready_o),
      .rd_valid_o      (rd_valid_o),
      .rd_data_o       (rd_data_o),
      .rd_fix_o        (rd_fix_o),
      .rd_unc_o        (rd_unc_o),
      .lane_rd_req_o   (lane_rd_req_o),
      .lane_rd_addr_o  (lane_rd_addr_o),
      .lane_rd_valid_i (lane_rd_valid_i),
      .lane_rd_bit_i   (lane_rd_bit_i),
      .lane_rd_err_i   (lane_rd_err_i)
   );
endmodule

// File: tb/bitstripe_engine_bench.sv
module bitstripe_engine_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DL = 8;
   localparam int NL = DL + 1;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_valid = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DL-1:0] wr_data = '0;
   logic          rd_req = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          rd_ready, rd_valid, rd_fix, rd_unc;
   logic [DL-1:0] rd_data;
   logic [NL-1:0] lane_wr_valid, lane_wr_bit, lane_rd_req;
   logic [AW-1:0] lane_wr_addr, lane_rd_addr;
   logic [NL-1:0] lane_rd_valid, lane_rd_bit, lane_rd_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   bitstripe_engine #(.DLANES(DL), .AW(AW)) u_bitstripe_engine (
      .clk_i(clk), .rst_i(rst),
      .wr_valid_i(wr_valid), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_req_i(rd_req), .rd_addr_i(rd_addr),
      .rd_ready_o(rd_ready), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
      .rd_fix_o(rd_fix), .rd_unc_o(rd_unc),
      .lane_wr_valid_o(lane_wr_valid), .lane_wr_bit_o(lane_wr_bit),
      .lane_wr_addr_o(lane_wr_addr),
      .lane_rd_req_o(lane_rd_req), .lane_rd_addr_o(lane_rd_addr),
      .lane_rd_valid_i(lane_rd_valid), .lane_rd_bit_i(lane_rd_bit),
      .lane_rd_err_i(lane_rd_err)
   );

   // lane model: one bit per lane per address, fixed latency per lane
   logic [NL-1:0] mem [1<<AW];
   logic [2:0]    cnt [NL];
   logic [AW-1:0] laddr [NL];
   int            lat [NL];
   logic [NL-1:0] inj = '0;

   initial begin
      for (int a = 0; a < (1<<AW); a++) mem[a] = '0;
      for (int i = 0; i < NL; i++) begin cnt[i] = '0; laddr[i] = '0; lat[i] = 1; end
   end

   always @(posedge clk) begin
      for (int i = 0; i < NL; i++) begin
         if (lane_wr_valid[i]) mem[lane_wr_addr][i] <= lane_wr_bit[i];
         if (lane_rd_req[i]) begin
            cnt[i]   <= 3'(lat[i]);
            laddr[i] <= lane_rd_addr;
         end else if (cnt[i] != 0) cnt[i] <= cnt[i] - 3'd1;
      end
   end

   always_comb begin
      for (int i = 0; i < NL; i++) begin
         lane_rd_valid[i] = (cnt[i] == 3'd1);
         lane_rd_bit[i]   = mem[laddr[i]][i] ^ inj[i];
         lane_rd_err[i]   = inj[i] & (cnt[i] == 3'd1);
      end
   end

   int checks = 0;
   int errors = 0;
   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor away from the edge
   int cyc = 0, last_v = -10, n_res = 0, dreq = 0, preq = 0, lat_bad = 0, bad_addr = 0;
   logic [DL-1:0] r_data;
   logic r_fix, r_unc;
   always @(negedge clk) begin
      cyc++;
      if (!rst) begin
         if (|lane_rd_valid) last_v = cyc;
         if (lane_rd_req[0]) begin
            dreq++;
            if (lane_rd_addr != rd_addr) bad_addr++;
         end
         if (lane_rd_req[DL]) preq++;
         if (rd_valid) begin
            n_res++;
            r_data = rd_data; r_fix = rd_fix; r_unc = rd_unc;
            if (cyc != last_v + 1) lat_bad++;
         end
      end
   end

   task automatic do_write(input logic [AW-1:0] a, input logic [DL-1:0] d);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
      chk(lane_wr_bit[DL-1:0] == d && lane_wr_addr == a, "R1 lane bits", int'(lane_wr_bit), int'(d));
      chk((^lane_wr_bit) == 1'b0 && lane_wr_bit[DL] == ^d, "R2 parity", int'(lane_wr_bit[DL]), int'(^d));
      chk(&lane_wr_valid, "R3 all lanes", int'(lane_wr_valid), (1<<NL)-1);
      @(negedge clk);
      chk(lane_wr_valid == '0, "R3 single cycle", int'(lane_wr_valid), 0);
   endtask

   // errcase: 0 clean, 1 single, 2 double, 3 single+parity, 4 clean slow
   task automatic do_read(input logic [AW-1:0] a, input logic [DL-1:0] exp, input int ec, input int v);
      logic [NL-1:0] m;
      bit unc_exp, fix_exp;
      int t;
      m = '0;
      if (ec == 1 || ec == 3) m[v % DL] = 1'b1;
      if (ec == 2) begin m[v % DL] = 1'b1; m[(v + 3) % DL] = 1'b1; end
      if (ec == 3) m[DL] = 1'b1;
      for (int i = 0; i < NL; i++) lat[i] = (ec == 4) ? 1 + ((v + 2*i) % 5) : 1 + ((v + i) % 3);
      inj = m;
      fix_exp = (ec == 1);
      unc_exp = (ec == 2 || ec == 3);
      n_res = 0; dreq = 0; preq = 0; lat_bad = 0; bad_addr = 0;
      @(negedge clk);
      chk(rd_ready, "R9 ready before read", int'(rd_ready), 1);
      rd_req = 1'b1; rd_addr = a;
      wr_valid = 1'b1; wr_addr = a ^ 4'h8; wr_data = ~exp;   // concurrent write
      @(negedge clk);
      wr_valid = 1'b0;
      chk(&lane_wr_valid && lane_wr_bit[DL-1:0] == ~exp && lane_wr_addr == (a ^ 4'h8),
          "R1 concurrent write", int'(lane_wr_bit), int'(~exp));
      rd_req = 1'b1; rd_addr = a;                              // busy: must be ignored
      @(negedge clk);
      rd_req = 1'b0;
      t = 0;
      while (n_res == 0 && t < 60) begin @(negedge clk); t++; end
      repeat (6) @(negedge clk);
      chk(n_res == 1, "R8 one result", n_res, 1);
      chk(lat_bad == 0, "R8 latency", lat_bad, 0);
      chk(dreq == 1 && bad_addr == 0, "R10 one data request", dreq, 1);
      chk(preq == ((ec == 1 || ec == 3) ? 1 : 0), (ec == 0 || ec == 4) ? "R4 parity idle" : "R6 parity request",
          preq, (ec == 1 || ec == 3) ? 1 : 0);
      if (unc_exp)
         chk(r_unc && !r_fix && r_data == '0, "R7 uncorrectable", {r_unc, r_fix, r_data}, {2'b10, 8'h00});
      else if (fix_exp)
         chk(!r_unc && r_fix && r_data == exp, "R6 rebuilt", {r_unc, r_fix, r_data}, {2'b01, exp});
      else
         chk(!r_unc && !r_fix && r_data == exp, "R5 clean read", {r_unc, r_fix, r_data}, {2'b00, exp});
      inj = '0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk(lane_wr_valid == '0 && lane_rd_req == '0 && !rd_valid, "R9 reset outputs",
          int'({lane_wr_valid, lane_rd_req}), 0);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(rd_ready, "R9 ready after reset", int'(rd_ready), 1);
      for (int v = 0; v < 256; v++) begin
         logic [AW-1:0] a;
         a = AW'(v % 8);
         do_write(a, DL'(v));
         do_read(a, DL'(v), v % 5, v);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule